// File: doc/BRIEF.md
# Two-Wire Bus Timing Compliance Monitor

This block watches the clock line and the data line of a two-wire serial bus (I2C) without ever driving them. It samples both lines with a fast system clock and passes each one through a two-flop synchronizer and a glitch filter. From the cleaned lines it detects bus conditions: a START, a repeated START, a STOP, and a data bit at every clock rise.

Between those events it counts the system-clock cycles of every interval that the bus timing rules constrain. It compares each count against a limit for standard mode or for fast mode. The `mode_fast` input selects the mode. Each limit is set in nanoseconds by a parameter and is turned into cycles when the block is elaborated. Minimums are rounded up. The clock-period limit that comes from the maximum frequency is rounded down.

A broken rule produces a one-cycle pulse carrying a 4-bit code. A sticky register keeps one bit per rule until software-independent logic pulses the clear input. A typical use is in a bus-level checker next to a controller or target model, or in silicon as a field diagnostic.

Top module: `i2c_timing_monitor`

## Requirements
- R1: A level on either line that lasts 50 ns or less (FILT_NS/CLK_NS cycles, rounded down) produces no edge and no event. A level that lasts one cycle longer is accepted.
- R2: Events are reported one per cycle at most. `ev_start` pulses when SDA falls while SCL is steadily high. `ev_restart` pulses with it when a transfer is already open. `ev_stop` pulses when SDA rises while SCL is steadily high, and this closes the transfer. `ev_bit` pulses at each SCL rise, with `bit_value` equal to SDA.
- R3: Code 1 is raised when SCL falls after a high phase shorter than the high-time minimum (4000 ns standard, 600 ns fast).
- R4: Code 2 is raised when SCL rises after a low phase shorter than the low-time minimum (4700 ns standard, 1300 ns fast).
- R5: Code 3 is raised when SCL rises less than the data setup minimum after the last SDA edge (250 ns standard, 100 ns fast).
- R6: Code 4 is raised when the first SCL fall after a START comes sooner than the START hold minimum (4000 ns standard, 600 ns fast).
- R7: Code 5 is raised only for a repeated START whose SDA fall comes sooner after the SCL rise than the setup minimum (4700 ns standard, 600 ns fast).
- R8: Code 6 is raised when the SDA rise of a STOP comes sooner after the SCL rise than the STOP setup minimum (4000 ns standard, 600 ns fast).
- R9: Code 7 is raised when a START follows the previous STOP sooner than the bus-free minimum (4700 ns standard, 1300 ns fast). There is no check when no STOP has been seen since reset.
- R10: Code 8 is raised when two consecutive SCL rises are closer than the period of the maximum clock rate (100 kHz standard, 400 kHz fast).
- R11: `mode_fast`=1 applies the fast limits and 0 applies the standard limits. An interval exactly equal to a limit is legal.
- R12: `viol_pulse` lasts one cycle per event cycle. `viol_code` carries the lowest code among the rules broken in that cycle and is 0 otherwise. Sticky bit code-1 is set for every rule broken, and all bits stay set.
- R13: `sticky_clr` zeroes the sticky register on the next edge. A rule broken in that same cycle still sets its bit.
- R14: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_fast | input | 1 | 1 selects fast-mode limits, 0 standard |
| sticky_clr | input | 1 | Clears the sticky violation register |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| ev_start | output | 1 | START or repeated START seen |
| ev_restart | output | 1 | The START seen was a repeated START |
| ev_stop | output | 1 | STOP seen |
| ev_bit | output | 1 | SCL rise, data bit sampled |
| bit_value | output | 1 | SDA value at the SCL rise |
| viol_pulse | output | 1 | One-cycle violation flag |
| viol_code | output | 4 | Code of the broken rule, 0 when none |
| viol_sticky | output | 8 | One sticky bit per rule, bit code-1 |

## Verification
The bench runs complete transfers, one interval at a time. Each broken rule is run one cycle short of its limit and then exactly at its limit. This separates an off-by-one in the cycle conversion or in the comparison from a correct boundary. One low phase is made too short for both the low time and the clock period. That case tells the priority of the reported code apart from the sticky bits it sets. Glitches five and six cycles long on each line, while the bus is idle, show the filter threshold. A standard-mode transfer whose high phase would pass in fast mode shows that the mode input really switches the limits.

// File: rtl/itm_pkg.sv
package itm_pkg;

  localparam int unsigned NRULE = 8;

  typedef enum logic [3:0] {
    CODE_NONE   = 4'd0,
    CODE_HIGH   = 4'd1,
    CODE_LOW    = 4'd2,
    CODE_SUDAT  = 4'd3,
    CODE_HDSTA  = 4'd4,
    CODE_SUSTA  = 4'd5,
    CODE_SUSTO  = 4'd6,
    CODE_BUF    = 4'd7,
    CODE_PERIOD = 4'd8
  } itm_code_e;

  // minimum interval: smallest whole cycle count that still reaches ns
  function automatic int unsigned cyc_ceil(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // lenient conversion used for limits derived from a maximum
  function automatic int unsigned cyc_floor(input int unsigned ns, input int unsigned clk_ns);
    return ns / clk_ns;
  endfunction

  function automatic int unsigned period_ns(input int unsigned khz);
    return 1000000 / khz;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // lowest broken rule wins the reported code
  function automatic logic [3:0] first_code(input logic [NRULE-1:0] hits);
    logic [3:0] c;
    c = 4'd0;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if (hits[i]) c = 4'(i + 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/itm_line_filter.sv
module itm_line_filter #(
  parameter int unsigned FILT_CYC = 5,
  parameter bit          IDLE     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic din_sync,
  output logic dout
);
  localparam int unsigned FW = $clog2(FILT_CYC + 2);

  logic          s1, s2;
  logic [FW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= IDLE;
      s2   <= IDLE;
      dout <= IDLE;
      run  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 != dout) begin
        if (run == FW'(FILT_CYC)) begin
          dout <= s2;
          run  <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end

  assign din_sync = s2;

endmodule

// File: rtl/itm_event_decode.sv
module itm_event_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_edge,
  output logic start,
  output logic stop,
  output logic busy
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (start)     busy <= 1'b1;
      else if (stop) busy <= 1'b0;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign sda_edge = sda_f ^ sda_q;
  assign start    = scl_f & scl_q & sda_q & ~sda_f;
  assign stop     = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/itm_interval_check.sv
module itm_interval_check
  import itm_pkg::*;
#(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_edge,
  input  logic          start,
  input  logic          stop,
  input  logic          busy,
  input  logic [CW-1:0] lim [NRULE],
  output logic [NRULE-1:0] hit
);
  logic [CW-1:0] c_scl, c_sda, c_sta, c_sto, c_per;
  logic          v_hi, v_lo, v_sda, v_sto, hd_pend;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
    return (c == '1) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_scl <= '0; c_sda <= '0; c_sta <= '0; c_sto <= '0; c_per <= '0;
      v_hi <= 1'b0; v_lo <= 1'b0; v_sda <= 1'b0; v_sto <= 1'b0;
      hd_pend <= 1'b0;
    end else begin
      c_scl <= (scl_rise | scl_fall) ? CW'(1) : sat_inc(c_scl);
      c_sda <= sda_edge ? CW'(1) : sat_inc(c_sda);
      c_sta <= start    ? CW'(1) : sat_inc(c_sta);
      c_sto <= stop     ? CW'(1) : sat_inc(c_sto);
      c_per <= scl_rise ? CW'(1) : sat_inc(c_per);
      if (scl_rise) v_hi  <= 1'b1;
      if (scl_fall) v_lo  <= 1'b1;
      if (sda_edge) v_sda <= 1'b1;
      if (stop)     v_sto <= 1'b1;
      if (start)         hd_pend <= 1'b1;
      else if (scl_fall) hd_pend <= 1'b0;
    end
  end

  always_comb begin
    hit    = '0;
    hit[0] = scl_fall & v_hi & (c_scl < lim[0]);
    hit[1] = scl_rise & v_lo & (c_scl < lim[1]);
    hit[2] = scl_rise & (sda_edge | (v_sda & (c_sda < lim[2])));
    hit[3] = scl_fall & hd_pend & (c_sta < lim[3]);
    hit[4] = start & busy & v_hi & (c_scl < lim[4]);
    hit[5] = stop & v_hi & (c_scl < lim[5]);
    hit[6] = start & ~busy & v_sto & (c_sto < lim[6]);
    hit[7] = scl_rise & v_hi & (c_per < lim[7]);
  end

endmodule

// File: rtl/i2c_timing_monitor.sv
module i2c_timing_monitor
  import itm_pkg::*;
#(
  parameter int unsigned CLK_NS       = 10,
  parameter int unsigned FILT_NS      = 50,
  parameter int unsigned STD_HIGH_NS  = 4000,
  parameter int unsigned FST_HIGH_NS  = 600,
  parameter int unsigned STD_LOW_NS   = 4700,
  parameter int unsigned FST_LOW_NS   = 1300,
  parameter int unsigned STD_SUDAT_NS = 250,
  parameter int unsigned FST_SUDAT_NS = 100,
  parameter int unsigned STD_HDSTA_NS = 4000,
  parameter int unsigned FST_HDSTA_NS = 600,
  parameter int unsigned STD_SUSTA_NS = 4700,
  parameter int unsigned FST_SUSTA_NS = 600,
  parameter int unsigned STD_SUSTO_NS = 4000,
  parameter int unsigned FST_SUSTO_NS = 600,
  parameter int unsigned STD_BUF_NS   = 4700,
  parameter int unsigned FST_BUF_NS   = 1300,
  parameter int unsigned STD_FMAX_KHZ = 100,
  parameter int unsigned FST_FMAX_KHZ = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_fast,
  input  logic             sticky_clr,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             ev_start,
  output logic             ev_restart,
  output logic             ev_stop,
  output logic             ev_bit,
  output logic             bit_value,
  output logic             viol_pulse,
  output logic [3:0]       viol_code,
  output logic [NRULE-1:0] viol_sticky
);
  localparam int unsigned FILT_CYC = cyc_floor(FILT_NS, CLK_NS);

  localparam int unsigned STD_LIM [NRULE] = '{
    cyc_ceil(STD_HIGH_NS,  CLK_NS), cyc_ceil(STD_LOW_NS,   CLK_NS),
    cyc_ceil(STD_SUDAT_NS, CLK_NS), cyc_ceil(STD_HDSTA_NS, CLK_NS),
    cyc_ceil(STD_SUSTA_NS, CLK_NS), cyc_ceil(STD_SUSTO_NS, CLK_NS),
    cyc_ceil(STD_BUF_NS,   CLK_NS), cyc_floor(period_ns(STD_FMAX_KHZ), CLK_NS)};
  localparam int unsigned FST_LIM [NRULE] = '{
    cyc_ceil(FST_HIGH_NS,  CLK_NS), cyc_ceil(FST_LOW_NS,   CLK_NS),
    cyc_ceil(FST_SUDAT_NS, CLK_NS), cyc_ceil(FST_HDSTA_NS, CLK_NS),
    cyc_ceil(FST_SUSTA_NS, CLK_NS), cyc_ceil(FST_SUSTO_NS, CLK_NS),
    cyc_ceil(FST_BUF_NS,   CLK_NS), cyc_floor(period_ns(FST_FMAX_KHZ), CLK_NS)};

  localparam int unsigned STD_MAX = max2(max2(max2(STD_LIM[0], STD_LIM[1]), max2(STD_LIM[2], STD_LIM[3])),
                                         max2(max2(STD_LIM[4], STD_LIM[5]), max2(STD_LIM[6], STD_LIM[7])));
  localparam int unsigned FST_MAX = max2(max2(max2(FST_LIM[0], FST_LIM[1]), max2(FST_LIM[2], FST_LIM[3])),
                                         max2(max2(FST_LIM[4], FST_LIM[5]), max2(FST_LIM[6], FST_LIM[7])));
  localparam int unsigned CW = $clog2(max2(STD_MAX, FST_MAX) + 2);

  // named internal wires, also observed by the bound checker
  logic [1:0] raw_lines, sync_lines, filt_lines;
  logic scl_s, sda_s, scl_f, sda_f;
  logic scl_rise, scl_fall, sda_edge, start, stop, busy;
  logic [CW-1:0]    lim [NRULE];
  logic [NRULE-1:0] hit;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    itm_line_filter #(.FILT_CYC(FILT_CYC), .IDLE(1'b1)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (raw_lines[g]),
      .din_sync (sync_lines[g]),
      .dout     (filt_lines[g])
    );
  end

  assign scl_s = sync_lines[0];
  assign sda_s = sync_lines[1];
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  for (genvar r = 0; r < NRULE; r++) begin : g_lim
    assign lim[r] = mode_fast ? CW'(FST_LIM[r]) : CW'(STD_LIM[r]);
  end

  itm_event_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_edge (sda_edge),
    .start    (start),
    .stop     (stop),
    .busy     (busy)
  );

  itm_interval_check #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_edge (sda_edge),
    .start    (start),
    .stop     (stop),
    .busy     (busy),
    .lim      (lim),
    .hit      (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_start    <= 1'b0;
      ev_restart  <= 1'b0;
      ev_stop     <= 1'b0;
      ev_bit      <= 1'b0;
      bit_value   <= 1'b0;
      viol_pulse  <= 1'b0;
      viol_code   <= 4'd0;
      viol_sticky <= '0;
    end else begin
      ev_start    <= start;
      ev_restart  <= start & busy;
      ev_stop     <= stop;
      ev_bit      <= scl_rise;
      bit_value   <= scl_rise & sda_f;
      viol_pulse  <= |hit;
      viol_code   <= first_code(hit);
      viol_sticky <= (sticky_clr ? '0 : viol_sticky) | hit;
    end
  end

endmodule

// File: rtl/i2c_timing_monitor_checker.sv
module i2c_timing_monitor_checker
  import itm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sticky_clr,
  input logic             scl_s,
  input logic             sda_s,
  input logic             scl_f,
  input logic             sda_f,
  input logic             ev_start,
  input logic             ev_restart,
  input logic             ev_stop,
  input logic             ev_bit,
  input logic             viol_pulse,
  input logic [3:0]       viol_code,
  input logic [NRULE-1:0] viol_sticky
);

  // R1: a filtered line only takes a value its synchronized input held
  a_r1_scl_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f != $past(scl_f)) |-> ($past(scl_s) == scl_f));
  a_r1_sda_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_f != $past(sda_f)) |-> ($past(sda_s) == sda_f));

  // R2: event reporting consistency
  a_r2_restart_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restart |-> ev_start);
  a_r2_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_start && ev_stop));
  a_r2_bit_alone: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bit |-> !(ev_start || ev_stop));

  // R12: code and sticky consistency
  a_r12_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> (viol_code != 4'd0 && viol_code <= 4'(NRULE)));
  a_r12_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_pulse |-> (viol_code == 4'd0));
  a_r12_sticky_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_pulse && viol_code != 4'd0 && viol_code <= 4'(NRULE)) |-> viol_sticky[viol_code - 4'd1]);
  a_r12_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_clr |=> ((viol_sticky & $past(viol_sticky)) == $past(viol_sticky)));

  // R13: clear empties the register unless a rule breaks at the same time
  a_r13_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_clr |=> (viol_pulse || viol_sticky == '0));

endmodule

bind i2c_timing_monitor i2c_timing_monitor_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sticky_clr  (sticky_clr),
  .scl_s       (scl_s),
  .sda_s       (sda_s),
  .scl_f       (scl_f),
  .sda_f       (sda_f),
  .ev_start    (ev_start),
  .ev_restart  (ev_restart),
  .ev_stop     (ev_stop),
  .ev_bit      (ev_bit),
  .viol_pulse  (viol_pulse),
  .viol_code   (viol_code),
  .viol_sticky (viol_sticky)
);

// File: tb/i2c_timing_monitor_tb_top.sv
module i2c_timing_monitor_tb_top;
  localparam int CLK_NS = 10;
  localparam int WATCHDOG = 200000;

  // fast-mode limits in cycles, restated from the requirements
  function automatic int up(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  localparam int F_HIGH = 60;   // 600 ns
  localparam int F_LOW  = 130;  // 1300 ns
  localparam int F_SU   = 10;   // 100 ns
  localparam int F_HD   = 60;
  localparam int F_STA  = 60;
  localparam int F_STO  = 60;
  localparam int F_BUF  = 130;
  localparam int S_HIGH = 400;  // 4000 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_fast = 1'b1;
  logic sticky_clr = 1'b0;
  logic scl_d = 1'b1;
  logic sda_d = 1'b1;
  logic ev_start, ev_restart, ev_stop, ev_bit, bit_value, viol_pulse;
  logic [3:0] viol_code;
  logic [7:0] viol_sticky;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  logic [7:0] exp_mask = 8'h00;

  int    vq[$];
  string vtag[$];
  int    eq[$];
  string etag[$];

  always #(CLK_NS / 2) clk = ~clk;

  i2c_timing_monitor dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_fast   (mode_fast),
    .sticky_clr  (sticky_clr),
    .scl_in      (scl_d),
    .sda_in      (sda_d),
    .ev_start    (ev_start),
    .ev_restart  (ev_restart),
    .ev_stop     (ev_stop),
    .ev_bit      (ev_bit),
    .bit_value   (bit_value),
    .viol_pulse  (viol_pulse),
    .viol_code   (viol_code),
    .viol_sticky (viol_sticky)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_ev(input int k, input string tag);
    eq.push_back(k);
    etag.push_back(tag);
  endtask

  task automatic exp_viol(input int c, input string tag);
    vq.push_back(c);
    vtag.push_back(tag);
    exp_mask[c-1] = 1'b1;
  endtask

  // kinds: 1 start, 2 repeated start, 3 stop, 4 bit 0, 5 bit 1
  task automatic do_start(input int hd);
    sda_d = 1'b0; exp_ev(1, "R2 start");
    wait_cyc(hd); scl_d = 1'b0;
  endtask

  task automatic do_bit(input bit b, input int ta, input int tsu, input int th);
    wait_cyc(ta); sda_d = b;
    wait_cyc(tsu); scl_d = 1'b1; exp_ev(4 + int'(b), "R2 bit");
    wait_cyc(th); scl_d = 1'b0;
  endtask

  task automatic do_stop(input int ta, input int tsu, input int su);
    wait_cyc(ta); sda_d = 1'b0;
    wait_cyc(tsu); scl_d = 1'b1; exp_ev(4, "R2 bit");
    wait_cyc(su); sda_d = 1'b1; exp_ev(3, "R2 stop");
  endtask

  task automatic do_rstart(input int ta, input int tsu, input int su, input int hd);
    wait_cyc(ta); sda_d = 1'b1;
    wait_cyc(tsu); scl_d = 1'b1; exp_ev(5, "R2 bit");
    wait_cyc(su); sda_d = 1'b0; exp_ev(2, "R7 repeated start");
    wait_cyc(hd); scl_d = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (viol_pulse) begin
        if (vq.size() == 0) check("R12 unexpected violation code", int'(viol_code), 0);
        else begin
          int c;
          string t;
          c = vq.pop_front();
          t = vtag.pop_front();
          check(t, int'(viol_code), c);
        end
      end
      if (ev_start || ev_stop || ev_bit) begin
        int k;
        k = ev_stop ? 3 : ev_start ? (ev_restart ? 2 : 1) : (bit_value ? 5 : 4);
        if (eq.size() == 0) check("R2 unexpected event kind", k, 0);
        else begin
          int e;
          string t;
          e = eq.pop_front();
          t = etag.pop_front();
          check(t, k, e);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(negedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(1);
    // R14: reset state
    check("R14 outputs after reset", int'({ev_start, ev_restart, ev_stop, ev_bit, bit_value, viol_pulse}), 0);
    check("R14 code after reset", int'(viol_code), 0);
    check("R14 sticky after reset", int'(viol_sticky), 0);
    mon_on = 1'b1;
    wait_cyc(100);

    // legal fast frame, byte 0xB2
    do_start(100);
    for (int i = 7; i >= 0; i--) do_bit(8'hB2 >> i, 60, 100, 120);
    do_stop(60, 100, 100);
    wait_cyc(20);
    check("R11 legal fast frame leaves sticky clear", int'(viol_sticky), 0);

    // bus free one short (R9), high time one short then at limit (R3), STOP setup short (R8)
    wait_cyc(F_BUF - 1 - 20);
    exp_viol(7, "R9 bus free short");
    do_start(100);
    do_bit(1, 60, 100, 120);
    exp_viol(1, "R3 high short");
    do_bit(0, 60, 100, F_HIGH - 1);
    do_bit(1, 200, 100, 120);
    do_bit(0, 60, 100, F_HIGH);
    do_bit(1, 200, 100, 120);
    exp_viol(6, "R8 stop setup short");
    do_stop(60, 100, F_STO - 1);

    // bus free exactly at limit, START hold short (R6)
    wait_cyc(F_BUF);
    exp_viol(4, "R6 start hold short");
    do_start(F_HD - 1);
    do_bit(1, 60, 100, 120);
    // low short and period short together: lowest code reported, both sticky (R4, R10, R12)
    exp_viol(2, "R4 low short with priority R12");
    exp_mask[7] = 1'b1;
    do_bit(0, 20, 100, 120);
    do_bit(1, F_LOW - 100, 100, 120);
    // setup short (R5), then at limit
    exp_viol(3, "R5 data setup short");
    do_bit(0, 150, F_SU - 1, 120);
    do_bit(1, 150, F_SU, 120);
    // period short alone (R10), then exactly 250 cycles
    do_bit(0, 60, 100, 69);
    exp_viol(8, "R10 period short");
    do_bit(1, 80, 100, 120);
    do_bit(0, 80, 100, 70);
    do_bit(1, 80, 100, 120);
    // repeated START setup short (R7), then at limit
    exp_viol(5, "R7 restart setup short");
    do_rstart(60, 100, F_STA - 1, 100);
    do_bit(0, 60, 100, 120);
    do_rstart(60, 100, F_STA, F_HD);
    do_bit(1, 60, 100, 120);
    do_stop(60, 100, F_STO);

    // glitch filter (R1)
    wait_cyc(200);
    sda_d = 1'b0; wait_cyc(5); sda_d = 1'b1;
    wait_cyc(50);
    scl_d = 1'b0; wait_cyc(5); scl_d = 1'b1;
    wait_cyc(50);
    sda_d = 1'b0; exp_ev(1, "R1 six-cycle low accepted as start");
    wait_cyc(6);
    sda_d = 1'b1; exp_ev(3, "R1 six-cycle level accepted as stop");

    // standard mode: a high time legal in fast mode is flagged (R11)
    wait_cyc(200);
    mode_fast = 1'b0;
    wait_cyc(up(4700) + 30);
    do_start(400);
    exp_viol(1, "R11 standard high short");
    do_bit(1, 250, 250, S_HIGH - 1);
    do_bit(0, 351, 250, 500);
    do_stop(400, 100, 400);

    wait_cyc(300);
    check("R12 sticky holds every broken rule", int'(viol_sticky), int'(exp_mask));
    sticky_clr = 1'b1;
    wait_cyc(1);
    sticky_clr = 1'b0;
    wait_cyc(2);
    check("R13 sticky after clear", int'(viol_sticky), 0);
    check("R12 violations left unreported", vq.size(), 0);
    check("R2 events left unreported", eq.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule